// File: doc/BRIEF.md
# Supply Supervisor with SRAM Access Gate

This block is the digital core of a supply supervisor that guards a battery-backed SRAM. It works from three digitised comparator results: supply above its trip level, supply below the battery switchover level, and power-fail sense input below its reference. It combines them with a free-running clock and the host's active-low chip-enable.

While the supply is out of tolerance, the block cuts the host off from the SRAM by holding the gated chip-enable inactive. It also asserts a system reset. When the supply comes back, both conditions are held for a fixed recovery interval, nominally 250 ms. This lets the supply and the processor settle before memory access is allowed again. The same interval applies after the block's own reset, which stands for a cold power-up.

The block also passes on the early-warning power-fail flag and drives the battery-select line. The power-fail flag is forced low while the supply runs from the battery. The recovery length is computed from the clock frequency and the nominal interval, and can be overridden in clock cycles.

Top module: `pwr_guard`

## Requirements
- R1: While `vcc_ok` is 0, `sram_ce_n` is 1 whatever the level of `host_ce_n`.
- R2: After `vcc_ok` goes to 1, SRAM access stays blocked (`sram_ce_n` = 1) until `vcc_ok` has been sampled 1 on RECOV_CYCLES consecutive rising clock edges. Access is allowed from the last of those edges.
- R3: `sys_rst_n` (active low) is 0 whenever `vcc_ok` is 0 and during the same recovery interval as R2. It is 1 exactly when access is allowed.
- R4: When access is allowed, `sram_ce_n` equals `host_ce_n` with no clock delay.
- R5: A 0 on `vcc_ok` sampled at any clock edge during the recovery interval restarts the interval from zero.
- R6: While `vcc_low` is 0, `pf_n` is the inverse of `pfi_low`. 0 means power fail.
- R7: While `vcc_low` is 1, `pf_n` is 0 whatever the level of `pfi_low`.
- R8: `bat_sel` equals `vcc_low`. 1 selects the backup battery.
- R9: After `rst_n` is released with `vcc_ok` at 1, access stays blocked and `sys_rst_n` stays 0 for a full recovery interval, counted as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock for the recovery counter |
| rst_n | input | 1 | Asynchronous active-low reset, treated as a cold power-up |
| vcc_ok | input | 1 | 1 when the supply is above the trip level |
| vcc_low | input | 1 | 1 when the supply is below the battery switchover level |
| pfi_low | input | 1 | 1 when the power-fail sense input is below its reference |
| host_ce_n | input | 1 | Host SRAM chip-enable, active low |
| sram_ce_n | output | 1 | Gated SRAM chip-enable, active low |
| sys_rst_n | output | 1 | System reset, active low |
| pf_n | output | 1 | Power-fail warning, active low |
| bat_sel | output | 1 | Battery-select, 1 selects the backup battery |

## Verification
The assertions assume that the comparator inputs are synchronous to `clk`, so the recovery counter sees clean levels at each edge. They also assume that `vcc_low` only matters as a level and needs no ordering against `vcc_ok`. The bench drives every input a little after the falling edge and compares on the next falling edge. In this way no input changes near a rising edge. The input combinations it drives include some that a real supply cannot produce, such as `vcc_low` high while `vcc_ok` is high. The design treats the comparator results as independent, so these combinations are legal.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  // recovery length in clock cycles from clock rate and interval in ms
  function automatic int unsigned recov_cycles_calc(input int unsigned clk_hz,
                                                    input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction

  // counter width able to hold values 0 .. n-1, at least one bit
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // power-fail level: forced low on battery, else inverse of comparator
  function automatic logic pf_level(input logic on_battery, input logic below_ref);
    return on_battery ? 1'b0 : ~below_ref;
  endfunction

  // gated chip-enable: inactive (1) when blocked, else host level
  function automatic logic ce_level(input logic blocked, input logic host_n);
    return blocked ? 1'b1 : host_n;
  endfunction

endpackage

// File: rtl/pwr_guard_timer.sv
module pwr_guard_timer
  import pwr_guard_pkg::*;
#(
  parameter int unsigned RECOV_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  output logic ready
);

  localparam int unsigned CW = cnt_width(RECOV_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RECOV_CYCLES - 1);

  logic [CW-1:0] elapsed;
  logic          at_last;

  assign at_last = (elapsed == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      ready   <= 1'b0;
    end else if (!vcc_ok) begin
      elapsed <= '0;
      ready   <= 1'b0;
    end else if (!ready) begin
      if (at_last) ready   <= 1'b1;
      else         elapsed <= elapsed + 1'b1;
    end
  end

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> (elapsed == '0 && !ready));

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(vcc_ok) && $past(elapsed) == LAST));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed <= LAST);

endmodule

// File: rtl/pwr_guard_ce_gate.sv
module pwr_guard_ce_gate
  import pwr_guard_pkg::*;
(
  input  logic vcc_ok,
  input  logic ready,
  input  logic host_ce_n,
  output logic blocked,
  output logic sram_ce_n,
  output logic sys_rst_n
);

  always_comb begin
    blocked   = ~vcc_ok | ~ready;
    sram_ce_n = ce_level(blocked, host_ce_n);
    sys_rst_n = ~blocked;
  end

endmodule

// File: rtl/pwr_guard_pf.sv
module pwr_guard_pf
  import pwr_guard_pkg::*;
(
  input  logic vcc_low,
  input  logic pfi_low,
  output logic pf_n,
  output logic bat_sel
);

  always_comb begin
    bat_sel = vcc_low;
    pf_n    = pf_level(vcc_low, pfi_low);
  end

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned RECOV_MS     = 250,
  parameter int unsigned RECOV_CYCLES = recov_cycles_calc(CLK_HZ, RECOV_MS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  input  logic vcc_low,
  input  logic pfi_low,
  input  logic host_ce_n,
  output logic sram_ce_n,
  output logic sys_rst_n,
  output logic pf_n,
  output logic bat_sel
);

  logic ready;
  logic blocked;

  pwr_guard_timer #(.RECOV_CYCLES(RECOV_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .vcc_ok (vcc_ok),
    .ready  (ready)
  );

  pwr_guard_ce_gate u_gate (
    .vcc_ok    (vcc_ok),
    .ready     (ready),
    .host_ce_n (host_ce_n),
    .blocked   (blocked),
    .sram_ce_n (sram_ce_n),
    .sys_rst_n (sys_rst_n)
  );

  pwr_guard_pf u_pf (
    .vcc_low (vcc_low),
    .pfi_low (pfi_low),
    .pf_n    (pf_n),
    .bat_sel (bat_sel)
  );

  // R1
  ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |-> sram_ce_n);

  // R3
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |-> (vcc_ok && $past(vcc_ok)));

  // R4
  ce_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> (!host_ce_n && sys_rst_n));

  // R7
  pf_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low |-> (!pf_n && bat_sel));

  // R6
  pf_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_low |-> (pf_n == !pfi_low));

endmodule

// File: tb/pwr_guard_test.sv
module pwr_guard_test;

  localparam int RECOV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b1, vcc_low = 1'b0, pfi_low = 1'b0, host_ce_n = 1'b1;
  logic sram_ce_n, sys_rst_n, pf_n, bat_sel;

  int checks = 0;
  int errors = 0;
  int run = 0;        // consecutive edges with supply good
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_guard #(.RECOV_CYCLES(RECOV)) uut (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_low(vcc_low),
    .pfi_low(pfi_low), .host_ce_n(host_ce_n), .sram_ce_n(sram_ce_n),
    .sys_rst_n(sys_rst_n), .pf_n(pf_n), .bat_sel(bat_sel)
  );

  // behavioural reference: count good-supply edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) run = 0;
    else if (vcc_ok) begin
      if (run < RECOV) run = run + 1;
    end else run = 0;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    bit open;
    cycles++;
    if (rst_n) begin
      open = vcc_ok && (run >= RECOV);
      check(!vcc_ok ? "R1" : (open ? "R4" : "R2"), sram_ce_n, open ? host_ce_n : 1'b1);
      check("R3", sys_rst_n, open);
      check(vcc_low ? "R7" : "R6", pf_n, vcc_low ? 1'b0 : !pfi_low);
      check("R8", bat_sel, vcc_low);
    end
    host_ce_n <= ~host_ce_n ^ cycles[2];
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // count sampled cycles with reset still active, starting after a rise
  task automatic measure(input string req);
    int low = 0;
    step(1);
    while (sys_rst_n === 1'b0 && low < 4 * RECOV) begin
      low++;
      step(1);
    end
    checks++;
    if (low != RECOV - 1) begin
      errors++;
      $display("FAIL %s: recovery low cycles actual %0d expected %0d", req, low, RECOV - 1);
    end
  endtask

  initial begin
    step(3);
    // reset state: access blocked (R9)
    checks++;
    if (sram_ce_n !== 1'b1 || sys_rst_n !== 1'b0) begin
      errors++;
      $display("FAIL R9: reset state ce=%b rst=%b expected 1/0", sram_ce_n, sys_rst_n);
    end
    @(negedge clk); #1 rst_n = 1'b1;
    measure("R9");
    step(10);
    // supply drop, host keeps trying (R1)
    vcc_ok = 1'b0; step(8);
    vcc_low = 1'b1; pfi_low = 1'b0; step(4);   // R7 battery forces pf low
    pfi_low = 1'b1; step(4);
    vcc_low = 1'b0; step(3);                   // R6 follow comparator
    pfi_low = 1'b0; step(2);
    vcc_ok = 1'b1;
    measure("R2");
    step(6);
    // drop mid interval restarts (R5)
    vcc_ok = 1'b0; step(2);
    vcc_ok = 1'b1; step(RECOV / 2);
    vcc_ok = 1'b0; step(1);
    vcc_ok = 1'b1;
    measure("R5");
    // one-cycle glitch once open (R1, R3)
    step(5);
    vcc_ok = 1'b0; step(1);
    vcc_ok = 1'b1;
    measure("R3");
    // pf toggles while powered (R6)
    for (int i = 0; i < 12; i++) begin
      pfi_low = i[0]; vcc_low = (i % 5 == 4); step(1);
    end
    vcc_low = 1'b0; step(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule